// File: doc/BRIEF.md
# Systolic Integral Image Grid

This block is a rectangular grid of processing cells, one per pixel, that turns a streamed frame into its summed-area table and, alongside it, the summed-area table of squared pixel values. Every row of the frame enters at once on its own lane. The columns arrive one per clock, leftmost first. Pixels ripple rightward through each row. Each cell compares its own column index with a global step counter to decide whether the pixel passing through belongs in its running row sum. A short vertical pass then folds each row's sums into the row below, one row per cycle from the top down. After that pass, every cell holds the total of all pixels above it and to its left, its own pixel included.

A single-cycle `start` opens a frame. `busy` stays high while the grid is working. `done` pulses once when the tables are complete. Any cell can then be read through a row and column address. The grid is meant to feed window-sum and variance logic that needs random access to both tables.

Top module: `iimg_grid`

## Requirements
- R1: After reset, `busy` and `done` are low and every readable cell returns zero on both `rd_sum` and `rd_sq`.
- R2: After `done`, reading address (r, c) returns on `rd_sum` the sum of pixel(i, j) over all i <= r and j <= c.
- R3: After `done`, reading address (r, c) returns on `rd_sq` the sum of pixel(i, j) squared over all i <= r and j <= c.
- R4: Accumulators never wrap. A frame of all maximum pixels gives (r+1)*(c+1)*255 on `rd_sum` and (r+1)*(c+1)*65025 on `rd_sq` at every cell, including the bottom-right cell.
- R5: The rising edge that samples `start` is edge 0. The lane for row r is bits [r*PIX_W +: PIX_W] of `pix_col`, and column k of the frame is sampled at edge k+1. `busy` is high after edges 0 through L-1, where L = 2*COLS+ROWS-2. `done` is high for exactly the one cycle after edge L.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The frame in progress completes with its own timing and results.
- R7: A row address at or above ROWS returns zero on both read outputs.
- R8: A new frame clears all results of the previous frame before it accumulates.
- R9: Pixel lanes are ignored outside the load window (edges 1 to COLS after `start`), both during the rest of the computation and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new frame when the grid is idle |
| pix_col | input | ROWS*PIX_W | One pixel per row lane for the current column |
| rd_row | input | max(1,clog2(ROWS)) | Read row address |
| rd_col | input | max(1,clog2(COLS)) | Read column address |
| busy | output | 1 | Grid is loading or accumulating |
| done | output | 1 | One-cycle pulse when both tables are complete |
| rd_sum | output | PIX_W+clog2(ROWS*COLS) | Integral value at the addressed cell |
| rd_sq | output | 2*PIX_W+clog2(ROWS*COLS) | Integral of squares at the addressed cell |

## Verification
The monotonic-accumulator assertions rely on one condition: nothing but an accepted `start` ever clears a cell while a frame runs. The stimulus therefore sends its extra `start` only while `busy` is high, in the middle of the sweep. The read-port assertion assumes the address is not read as meaningful during `busy`, so every address the stimulus applies to the read port comes after `done`. The stimulus also drives random values onto the pixel lanes in every cycle outside the load window. Without that, the assertion and scoreboard results would depend on the lanes being held quiet.

// File: rtl/iimg_pkg.sv
package iimg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2,
      PH_END  = 2'd3
   } phase_e;

   function automatic int acc_bits(input int base, input int cells);
      return base + $clog2(cells);
   endfunction

   function automatic int addr_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/iimg_ctrl.sv
module iimg_ctrl
   import iimg_pkg::*;
#(
   parameter int ROWS = 6,
   parameter int COLS = 8,
   parameter int TW   = 4,
   parameter int VW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          clr,
   output logic          h_step,
   output logic [TW-1:0] t,
   output logic          v_step,
   output logic [VW-1:0] v,
   output logic          busy,
   output logic          done
);

   localparam logic [TW-1:0] T_LAST = TW'(2*COLS-2);
   localparam logic [VW-1:0] V_LAST = VW'(ROWS-1);

   phase_e ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE;
         t  <= '0;
         v  <= '0;
      end else begin
         case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph <= PH_ROW;
                  t  <= '0;
                  v  <= '0;
               end
            end
            PH_ROW: begin
               if (t == T_LAST) begin
                  t <= '0;
                  if (ROWS > 1) begin
                     ph <= PH_COL;
                     v  <= VW'(1);
                  end else begin
                     ph <= PH_END;
                  end
               end else begin
                  t <= t + TW'(1);
               end
            end
            PH_COL: begin
               if (v == V_LAST) begin
                  ph <= PH_END;
                  v  <= '0;
               end else begin
                  v <= v + VW'(1);
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign clr    = start && (ph == PH_IDLE);
   assign h_step = (ph == PH_ROW);
   assign v_step = (ph == PH_COL);
   assign busy   = h_step || v_step;
   assign done   = (ph == PH_END);

   // R5: completion is a single-cycle pulse
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: the working interval always ends in the completion pulse
   assert_busy_ends_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6: a start seen mid-sweep does not disturb the step counter
   assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (h_step && (t != T_LAST) && start) |=> (h_step && (t == $past(t) + TW'(1))));

   // R2: the vertical fold never addresses the top row
   assert_fold_skips_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      v_step |-> (v != '0));

endmodule

// File: rtl/iimg_cell.sv
module iimg_cell #(
   parameter int ROW   = 0,
   parameter int COL   = 0,
   parameter int PIX_W = 8,
   parameter int SW    = 14,
   parameter int QW    = 22,
   parameter int TW    = 4,
   parameter int VW    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               h_step,
   input  logic [TW-1:0]      t,
   input  logic               v_step,
   input  logic [VW-1:0]      v,
   input  logic [PIX_W-1:0]   pix_in,
   input  logic [2*PIX_W-1:0] sq_in,
   output logic [PIX_W-1:0]   pix_out,
   output logic [2*PIX_W-1:0] sq_out,
   input  logic [SW-1:0]      up_sum,
   input  logic [QW-1:0]      up_sq,
   output logic [SW-1:0]      sum,
   output logic [QW-1:0]      sq
);

   localparam logic [TW-1:0] T_LO = TW'(COL);
   localparam logic [TW-1:0] T_HI = TW'(2*COL);
   localparam logic [VW-1:0] V_ME = VW'(ROW);

   logic in_win;
   logic h_add;
   logic v_add;

   // Pixel of column k passes this cell at step k+COL; keep it when k <= COL.
   generate
      if (COL == 0) begin : g_first
         assign in_win = (t == '0);
      end else begin : g_rest
         assign in_win = (t >= T_LO) && (t <= T_HI);
      end
   endgenerate

   assign h_add = h_step && in_win;
   assign v_add = v_step && (v == V_ME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_out <= '0;
         sq_out  <= '0;
         sum     <= '0;
         sq      <= '0;
      end else if (clr) begin
         pix_out <= '0;
         sq_out  <= '0;
         sum     <= '0;
         sq      <= '0;
      end else begin
         if (h_step) begin
            pix_out <= pix_in;
            sq_out  <= sq_in;
         end
         if (h_add) begin
            sum <= sum + SW'(pix_in);
            sq  <= sq + QW'(sq_in);
         end else if (v_add) begin
            sum <= sum + up_sum;
            sq  <= sq + up_sq;
         end
      end
   end

   // R4: accumulation never wraps
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (h_add || v_add) |=> ((sum >= $past(sum)) && (sq >= $past(sq))));

   // R2: row sweep and column fold are never active together
   assert_one_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_add && v_add));

endmodule

// File: rtl/iimg_rdmux.sv
module iimg_rdmux #(
   parameter int ROWS   = 6,
   parameter int COLS   = 8,
   parameter int SW     = 14,
   parameter int QW     = 22,
   parameter int RAW    = 3,
   parameter int CAW    = 3,
   parameter bit RD_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RAW-1:0]       rd_row,
   input  logic [CAW-1:0]       rd_col,
   input  logic [ROWS*COLS*SW-1:0] sum_flat,
   input  logic [ROWS*COLS*QW-1:0] sq_flat,
   output logic [SW-1:0]        rd_sum,
   output logic [QW-1:0]        rd_sq
);

   logic [SW-1:0] sel_s;
   logic [QW-1:0] sel_q;
   logic          in_range;

   assign in_range = ({1'b0, rd_row} < (RAW+1)'(ROWS)) &&
                     ({1'b0, rd_col} < (CAW+1)'(COLS));

   always_comb begin
      sel_s = '0;
      sel_q = '0;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            if ((rd_row == RAW'(r)) && (rd_col == CAW'(c))) begin
               sel_s = sum_flat[(r*COLS+c)*SW +: SW];
               sel_q = sq_flat[(r*COLS+c)*QW +: QW];
            end
         end
      end
   end

   generate
      if (RD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_sum <= '0;
               rd_sq  <= '0;
            end else begin
               rd_sum <= sel_s;
               rd_sq  <= sel_q;
            end
         end
         // R7: an address past the last row reads as zero one cycle later
         assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_range |=> ((rd_sum == '0) && (rd_sq == '0)));
      end else begin : g_comb
         assign rd_sum = sel_s;
         assign rd_sq  = sel_q;
         // R7: an address past the last row reads as zero
         assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_range |-> ((rd_sum == '0) && (rd_sq == '0)));
      end
   endgenerate

endmodule

// File: rtl/iimg_grid.sv
module iimg_grid
   import iimg_pkg::*;
#(
   parameter int ROWS   = 6,
   parameter int COLS   = 8,
   parameter int PIX_W  = 8,
   parameter bit RD_REG = 1'b0,
   localparam int SW    = acc_bits(PIX_W, ROWS*COLS),
   localparam int QW    = acc_bits(2*PIX_W, ROWS*COLS),
   localparam int RAW   = addr_bits(ROWS),
   localparam int CAW   = addr_bits(COLS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ROWS*PIX_W-1:0] pix_col,
   input  logic [RAW-1:0]        rd_row,
   input  logic [CAW-1:0]        rd_col,
   output logic                  busy,
   output logic                  done,
   output logic [SW-1:0]         rd_sum,
   output logic [QW-1:0]         rd_sq
);

   localparam int TW = $clog2(2*COLS);
   localparam int VW = $clog2(ROWS+1);
   localparam int QPW = 2*PIX_W;

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_dims
         $error("iimg_grid: ROWS and COLS must be at least 1");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("iimg_grid: PIX_W must be at least 1");
      end
      if (ROWS*COLS > 4096) begin : g_bad_size
         $error("iimg_grid: grid larger than 4096 cells");
      end
   endgenerate

   logic          clr;
   logic          h_step;
   logic          v_step;
   logic [TW-1:0] t;
   logic [VW-1:0] v;

   iimg_ctrl #(
      .ROWS (ROWS),
      .COLS (COLS),
      .TW   (TW),
      .VW   (VW)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .clr    (clr),
      .h_step (h_step),
      .t      (t),
      .v_step (v_step),
      .v      (v),
      .busy   (busy),
      .done   (done)
   );

   logic [PIX_W-1:0] hp [ROWS][COLS+1];
   logic [QPW-1:0]   hq [ROWS][COLS+1];
   logic [SW-1:0]    cs [ROWS][COLS];
   logic [QW-1:0]    cq [ROWS][COLS];
   logic [ROWS*COLS*SW-1:0] sum_flat;
   logic [ROWS*COLS*QW-1:0] sq_flat;

   genvar r, c;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         logic [PIX_W-1:0] lane;
         assign lane     = pix_col[r*PIX_W +: PIX_W];
         assign hp[r][0] = lane;
         // squares are formed once per row lane and travel with the pixel
         assign hq[r][0] = QPW'(lane) * QPW'(lane);

         for (c = 0; c < COLS; c++) begin : g_col
            logic [SW-1:0] above_s;
            logic [QW-1:0] above_q;

            if (r == 0) begin : g_top
               assign above_s = '0;
               assign above_q = '0;
            end else begin : g_below
               assign above_s = cs[r-1][c];
               assign above_q = cq[r-1][c];
            end

            iimg_cell #(
               .ROW   (r),
               .COL   (c),
               .PIX_W (PIX_W),
               .SW    (SW),
               .QW    (QW),
               .TW    (TW),
               .VW    (VW)
            ) u_cell (
               .clk     (clk),
               .rst_n   (rst_n),
               .clr     (clr),
               .h_step  (h_step),
               .t       (t),
               .v_step  (v_step),
               .v       (v),
               .pix_in  (hp[r][c]),
               .sq_in   (hq[r][c]),
               .pix_out (hp[r][c+1]),
               .sq_out  (hq[r][c+1]),
               .up_sum  (above_s),
               .up_sq   (above_q),
               .sum     (cs[r][c]),
               .sq      (cq[r][c])
            );

            assign sum_flat[(r*COLS+c)*SW +: SW] = cs[r][c];
            assign sq_flat[(r*COLS+c)*QW +: QW]  = cq[r][c];
         end
      end
   endgenerate

   iimg_rdmux #(
      .ROWS   (ROWS),
      .COLS   (COLS),
      .SW     (SW),
      .QW     (QW),
      .RAW    (RAW),
      .CAW    (CAW),
      .RD_REG (RD_REG)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_row   (rd_row),
      .rd_col   (rd_col),
      .sum_flat (sum_flat),
      .sq_flat  (sq_flat),
      .rd_sum   (rd_sum),
      .rd_sq    (rd_sq)
   );

   // R8: an accepted start empties the bottom-right cell on the next cycle
   assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> ((cs[ROWS-1][COLS-1] == '0) && (cq[ROWS-1][COLS-1] == '0)));

endmodule

// File: tb/sim_iimg_grid.sv
module sim_iimg_grid;

   localparam int R   = 6;
   localparam int C   = 8;
   localparam int P   = 8;
   localparam int SW  = P + $clog2(R*C);
   localparam int QW  = 2*P + $clog2(R*C);
   localparam int RAW = 3;
   localparam int CAW = 3;
   localparam int L   = 2*C + R - 2;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           start;
   logic [R*P-1:0] pix_col;
   logic [RAW-1:0] rd_row;
   logic [CAW-1:0] rd_col;
   logic           busy;
   logic           done;
   logic [SW-1:0]  rd_sum;
   logic [QW-1:0]  rd_sq;

   always #10ns clk = ~clk;

   iimg_grid #(
      .ROWS  (R),
      .COLS  (C),
      .PIX_W (P)
   ) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .pix_col (pix_col),
      .rd_row  (rd_row),
      .rd_col  (rd_col),
      .busy    (busy),
      .done    (done),
      .rd_sum  (rd_sum),
      .rd_sq   (rd_sq)
   );

   typedef struct {
      int    row;
      int    col;
      int    es;
      int    eq;
      string tag;
   } item_t;

   item_t sbq[$];
   int    errs   = 0;
   int    checks = 0;
   int    pix [R][C];
   int    ref_s [R][C];
   int    ref_q [R][C];

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic calc_ref();
      for (int r = 0; r < R; r++) begin
         for (int c = 0; c < C; c++) begin
            int s = 0;
            int q = 0;
            for (int i = 0; i <= r; i++) begin
               for (int j = 0; j <= c; j++) begin
                  s += pix[i][j];
                  q += pix[i][j] * pix[i][j];
               end
            end
            ref_s[r][c] = s;
            ref_q[r][c] = q;
         end
      end
   endtask

   task automatic drive_col(input int k);
      for (int r = 0; r < R; r++) pix_col[r*P +: P] = P'(pix[r][k]);
   endtask

   // R5, R6, R9: one frame with cycle-exact checks on busy and done
   task automatic run_frame(input bit inject);
      calc_ref();
      @(negedge clk);
      start   = 1'b1;
      pix_col = R*P'($urandom);
      for (int e = 0; e <= L + 1; e++) begin
         @(posedge clk);
         @(negedge clk);
         start = inject && (e == C + 1);
         if (e < C) drive_col(e);
         else pix_col = {$urandom, $urandom};
         chk(done == (e == L), $sformatf("R5 done after edge %0d", e), done, (e == L));
         chk(busy == (e < L), $sformatf("R5 busy after edge %0d", e), busy, (e < L));
      end
      start = 1'b0;
   endtask

   task automatic push_read(input int r, input int c, input int es, input int eq, input string tag);
      item_t it;
      @(negedge clk);
      rd_row = RAW'(r);
      rd_col = CAW'(c);
      it.row = r; it.col = c; it.es = es; it.eq = eq; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic drain();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   task automatic read_all(input string tag);
      for (int r = 0; r < R; r++)
         for (int c = 0; c < C; c++)
            push_read(r, c, ref_s[r][c], ref_q[r][c], tag);
      drain();
   endtask

   // monitor: compares read data in the middle of the high phase
   initial begin
      forever begin
         @(posedge clk);
         #5ns;
         if (sbq.size() != 0) begin
            item_t it;
            it = sbq.pop_front();
            chk(int'(rd_sum) == it.es,
                $sformatf("%s sum at (%0d,%0d)", it.tag, it.row, it.col), rd_sum, it.es);
            chk(int'(rd_sq) == it.eq,
                $sformatf("%s sq at (%0d,%0d)", it.tag, it.row, it.col), rd_sq, it.eq);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      start   = 1'b0;
      pix_col = '0;
      rd_row  = '0;
      rd_col  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk(!busy, "R1 busy after reset", busy, 0);
      chk(!done, "R1 done after reset", done, 0);
      push_read(0, 0, 0, 0, "R1");
      push_read(R-1, C-1, 0, 0, "R1");
      push_read(2, 5, 0, 0, "R1");
      drain();

      // R2, R3: random frame
      for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) pix[r][c] = $urandom_range(0, 255);
      run_frame(1'b0);
      read_all("R2/R3 random");

      // R9: idle lane activity leaves results untouched
      repeat (12) begin
         @(negedge clk);
         pix_col = {$urandom, $urandom};
      end
      push_read(R-1, C-1, ref_s[R-1][C-1], ref_q[R-1][C-1], "R9 idle");
      push_read(3, 4, ref_s[3][4], ref_q[3][4], "R9 idle");
      drain();

      // R7: row past the grid reads as zero
      push_read(R, 0, 0, 0, "R7 row oob");
      push_read(R + 1, C - 1, 0, 0, "R7 row oob");
      drain();

      // R4: all-maximum frame
      for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) pix[r][c] = 255;
      run_frame(1'b0);
      read_all("R4 full scale");

      // R8: zero frame after full scale must read all zero
      for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) pix[r][c] = 0;
      run_frame(1'b0);
      read_all("R8 cleared");

      // R6, R9: restart request mid-sweep and noisy lanes outside the load window
      for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) pix[r][c] = (r * 37 + c * 11 + 5) % 256;
      run_frame(1'b1);
      read_all("R6/R9 restart ignored");

      // R2, R3: sparse pattern, single bright pixel per row
      for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) pix[r][c] = (c == (r % C)) ? 200 : 0;
      run_frame(1'b0);
      read_all("R2/R3 sparse");

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule